// File: doc/BRIEF.md
# Byte-Lane Controller for an Asynchronous Static RAM

This block lets a clocked host use an asynchronous static RAM of 512K words by 32 bits. The host hands over one request at a time through a valid/ready pair carrying an address, a write flag, write data and four byte strobes. Read results come back as a one-cycle response pulse with the data. On the memory side the controller drives a word address and four active-low enables, one per byte lane. It also drives a shared active-low write strobe and a shared active-low output-enable strobe, and it owns a tri-state 32-bit data bus.

Byte masking is done only by the per-lane enables: a lane whose enable stays high takes no part in the access. All strobe widths come from clock counts. The controller rounds the worst-case nanosecond figure of the chosen speed grade (12, 15, 17 or 20 ns) up to whole clock periods. While the write strobe is low, the output enable is always held high.

A build-time option makes the same array look like 1M x 16. The lowest host address bit then picks the lower or upper pair of lanes, and the 16-bit host data is routed to and from that half of the bus. After a read, the first following write waits through a short bus-turnaround gap, so the memory's drivers have let go of the bus before the controller starts driving it.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and after reset, with no access in progress, all four lane enables, the write strobe and the output-enable strobe are high, the response valid is low, and req_ready is high.
- R2: The output-enable strobe is high in every cycle in which the write strobe is low.
- R3: A read holds the address, its lane enables and the low output-enable strobe for RD cycles. The data bus is sampled at the clock edge that ends this window, and rsp_valid is high for exactly one cycle, starting at that edge.
- R4: A write drives the address, its lane enables, the write data on the bus and the low write strobe for WR cycles. All of them are applied at the same clock edge and are withdrawn together at the edge that ends the window.
- R5: In 32-bit mode, lane i covers data bits 8i+7..8i. On a write, enable i is low exactly when strobe bit i is set, so a write with all strobes clear leaves the memory unchanged. A read drives all four enables low.
- R6: In 16-bit mode the host address is one bit wider. Bit 0 set selects lanes 2 and 3 (bus bits 31..16), and bit 0 clear selects lanes 0 and 1 (bits 15..0). The memory address is the host address shifted right by one. Write data bits 15..0 appear on the selected half, and only strobe bits 1..0 are used, mapped onto the selected pair. Read data returns in bits 15..0 with bits 31..16 zero.
- R7: When the previous access was a read, a write leaves all enables and the write strobe high for TA cycles after acceptance before the write strobe falls. After a write, the next write's strobe falls at the first edge following acceptance.
- R8: Each count is max(1, ceil(ns / clock period)). RD uses the grade figure. TA uses the output-release figure: 6, 7, 9 or 9 ns for grades 12, 15, 17 or 20. WR is the largest of three counts: the write pulse (8, 10, 11 or 12 ns), the data setup (6, 7, 8 or 9 ns), and the grade count minus one.
- R9: The controller drives the data bus only while the write strobe is low. Read data comes from the memory's drivers.
- R10: While an access is in progress req_ready is low, and a request presented then has no effect on the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W + HALF_MODE | Host word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte strobes |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 32 | Read data |
| mem_addr | output | ADDR_W | Memory word address |
| mem_ce_n | output | 4 | Active-low per-lane enables |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq | inout | 32 | Tri-state data bus |

## Verification
Two situations are hard to reach from the ports. The first is a request that arrives while an access is still running. The bench holds req_valid high with a write throughout a read window, and drops it on the first idle cycle. It then reads back the target word to show the memory was never touched. The second is the turnaround gap. The bench issues a write on the very first idle cycle after a read, counts the cycles from acceptance to the falling write strobe, and compares that count with a write issued straight after a write.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_TURN, ST_WRITE} seq_state_e;

  // whole clock periods covering a nanosecond minimum, never below one
  function automatic int ns_to_cycles(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int we_pulse_ns(input int grade);
    case (grade)
      12: return 8;
      15: return 10;
      17: return 11;
      default: return 12;
    endcase
  endfunction

  function automatic int data_setup_ns(input int grade);
    case (grade)
      12: return 6;
      15: return 7;
      17: return 8;
      default: return 9;
    endcase
  endfunction

  function automatic int oe_release_ns(input int grade);
    case (grade)
      12: return 6;
      15: return 7;
      default: return 9;
    endcase
  endfunction

  function automatic int read_cycles(input int grade, input int period_ns);
    return ns_to_cycles(grade, period_ns);
  endfunction

  function automatic int write_cycles(input int grade, input int period_ns);
    int a, b, c, m;
    a = ns_to_cycles(we_pulse_ns(grade), period_ns);
    b = ns_to_cycles(data_setup_ns(grade), period_ns);
    c = ns_to_cycles(grade, period_ns) - 1;
    m = (a > b) ? a : b;
    m = (m > c) ? m : c;
    return m;
  endfunction

  function automatic int turn_cycles(input int grade, input int period_ns);
    return ns_to_cycles(oe_release_ns(grade), period_ns);
  endfunction

endpackage

// File: rtl/sram_lane_map.sv
module sram_lane_map
  import sram_lane_pkg::*;
#(
  parameter int HALF_MODE = 0,
  parameter int ADDR_W    = 19,
  parameter int HOST_AW   = 19
) (
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [LANES-1:0]   host_be,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [ADDR_W-1:0]  word_addr,
  output logic [LANES-1:0]   wr_lanes,
  output logic [LANES-1:0]   rd_lanes,
  output logic [DATA_W-1:0]  lane_wdata,
  input  logic [LANES-1:0]   cap_lanes,
  input  logic [DATA_W-1:0]  raw_rdata,
  output logic [DATA_W-1:0]  host_rdata
);

  localparam int HALF_W = DATA_W / 2;

  generate
    if (HALF_MODE != 0) begin : g_half
      logic upper;
      logic [HALF_W+4:0] unused_half;
      assign upper      = host_addr[0];
      assign word_addr  = host_addr[HOST_AW-1:1];
      assign wr_lanes   = upper ? {host_be[1:0], 2'b00} : {2'b00, host_be[1:0]};
      assign rd_lanes   = upper ? 4'b1100 : 4'b0011;
      assign lane_wdata = {2{host_wdata[HALF_W-1:0]}};
      assign host_rdata = cap_lanes[2] ? {{HALF_W{1'b0}}, raw_rdata[DATA_W-1:HALF_W]}
                                       : {{HALF_W{1'b0}}, raw_rdata[HALF_W-1:0]};
      assign unused_half = {host_be[3:2], host_wdata[DATA_W-1:HALF_W], cap_lanes[3], cap_lanes[1:0]};
    end else begin : g_full
      assign word_addr  = host_addr;
      assign wr_lanes   = host_be;
      assign rd_lanes   = '1;
      assign lane_wdata = host_wdata;
      for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign host_rdata[i*LANE_W +: LANE_W] = cap_lanes[i] ? raw_rdata[i*LANE_W +: LANE_W]
                                                             : '0;
      end
    end
  endgenerate

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int RD_CYC = 2,
  parameter int WR_CYC = 2,
  parameter int TA_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_wr_lanes,
  input  logic [LANES-1:0]  in_rd_lanes,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              req_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              bus_drive,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [LANES-1:0]  cap_lanes,
  output logic              rd_done
);

  localparam int MAX_RW = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int MAX_C  = (MAX_RW > TA_CYC) ? MAX_RW : TA_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LAST = CNT_W'(TA_CYC - 1);

  seq_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [LANES-1:0]  lanes_q;
  logic [LANES-1:0]  ce_n_q;
  logic              we_n_q, oe_n_q, drive_q, last_rd;

  // named events for the checks below
  logic accept, cnt_zero, wr_done;
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign cnt_zero  = (cnt == '0);
  assign rd_done   = (state == ST_READ) && cnt_zero;
  assign wr_done   = (state == ST_WRITE) && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      lanes_q <= '0;
      ce_n_q  <= '1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      drive_q <= 1'b0;
      last_rd <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          addr_q <= in_addr;
          data_q <= in_wdata;
          if (req_write) begin
            lanes_q <= in_wr_lanes;
            if (last_rd) begin
              state <= ST_TURN;
              cnt   <= TA_LAST;
            end else begin
              state   <= ST_WRITE;
              cnt     <= WR_LAST;
              ce_n_q  <= ~in_wr_lanes;
              we_n_q  <= 1'b0;
              drive_q <= 1'b1;
            end
          end else begin
            lanes_q <= in_rd_lanes;
            state   <= ST_READ;
            cnt     <= RD_LAST;
            ce_n_q  <= ~in_rd_lanes;
            oe_n_q  <= 1'b0;
          end
        end
        ST_TURN: if (cnt_zero) begin
          state   <= ST_WRITE;
          cnt     <= WR_LAST;
          ce_n_q  <= ~lanes_q;
          we_n_q  <= 1'b0;
          drive_q <= 1'b1;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
        ST_READ: if (cnt_zero) begin
          state   <= ST_IDLE;
          ce_n_q  <= '1;
          oe_n_q  <= 1'b1;
          last_rd <= 1'b1;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
        ST_WRITE: if (cnt_zero) begin
          state   <= ST_IDLE;
          ce_n_q  <= '1;
          we_n_q  <= 1'b1;
          drive_q <= 1'b0;
          last_rd <= 1'b0;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_addr  = addr_q;
  assign mem_ce_n  = ce_n_q;
  assign mem_we_n  = we_n_q;
  assign mem_oe_n  = oe_n_q;
  assign bus_drive = drive_q;
  assign bus_wdata = data_q;
  assign cap_lanes = lanes_q;

  // strobe run lengths, for the width checks
  logic [CNT_W:0] we_run, oe_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run <= '0;
      oe_run <= '0;
    end else begin
      we_run <= mem_we_n ? '0 : we_run + (CNT_W+1)'(1);
      oe_run <= mem_oe_n ? '0 : oe_run + (CNT_W+1)'(1);
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n == '1 && mem_we_n && mem_oe_n && !bus_drive));

  p_we_blocks_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  p_read_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr) && $stable(mem_ce_n));

  p_write_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr) && $stable(bus_wdata) && $stable(mem_ce_n));

  p_we_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == (CNT_W+1)'(WR_CYC)));

  p_oe_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_run == (CNT_W+1)'(RD_CYC)));

  p_no_drive_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !bus_drive);

  p_release_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> (!bus_drive && mem_we_n));

  p_turn_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> mem_we_n);

  p_busy_no_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && req_valid) |=> ($stable(mem_addr) || req_ready));

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int GRADE_NS      = 20,
  parameter int HALF_MODE     = 0,
  parameter int ADDR_W        = 19,
  localparam int HOST_AW      = ADDR_W + ((HALF_MODE != 0) ? 1 : 0)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [HOST_AW-1:0] req_addr,
  input  logic [31:0]        req_wdata,
  input  logic [3:0]         req_be,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [3:0]         mem_ce_n,
  output logic               mem_we_n,
  output logic               mem_oe_n,
  inout  wire  [31:0]        mem_dq
);

  localparam int RD_CYC = read_cycles(GRADE_NS, CLK_PERIOD_NS);
  localparam int WR_CYC = write_cycles(GRADE_NS, CLK_PERIOD_NS);
  localparam int TA_CYC = turn_cycles(GRADE_NS, CLK_PERIOD_NS);

  logic [ADDR_W-1:0] word_addr;
  logic [LANES-1:0]  wr_lanes, rd_lanes, cap_lanes;
  logic [DATA_W-1:0] lane_wdata, bus_wdata, host_rdata;
  logic              bus_drive, rd_done;

  sram_lane_map #(
    .HALF_MODE (HALF_MODE),
    .ADDR_W    (ADDR_W),
    .HOST_AW   (HOST_AW)
  ) u_map (
    .host_addr  (req_addr),
    .host_be    (req_be),
    .host_wdata (req_wdata),
    .word_addr  (word_addr),
    .wr_lanes   (wr_lanes),
    .rd_lanes   (rd_lanes),
    .lane_wdata (lane_wdata),
    .cap_lanes  (cap_lanes),
    .raw_rdata  (mem_dq),
    .host_rdata (host_rdata)
  );

  sram_seq #(
    .ADDR_W (ADDR_W),
    .RD_CYC (RD_CYC),
    .WR_CYC (WR_CYC),
    .TA_CYC (TA_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .in_addr     (word_addr),
    .in_wr_lanes (wr_lanes),
    .in_rd_lanes (rd_lanes),
    .in_wdata    (lane_wdata),
    .req_ready   (req_ready),
    .mem_addr    (mem_addr),
    .mem_ce_n    (mem_ce_n),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .bus_drive   (bus_drive),
    .bus_wdata   (bus_wdata),
    .cap_lanes   (cap_lanes),
    .rd_done     (rd_done)
  );

  assign mem_dq = bus_drive ? bus_wdata : 'z;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_done;
      if (rd_done) rsp_rdata <= host_rdata;
    end
  end

  p_rsp_follows_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> rsp_valid);

  p_rsp_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;

  // expected counts at a 10 ns clock, worked out from R8
  localparam int F_RD = (20 + 9) / 10;  // grade 20: 2
  localparam int F_WR = (12 + 9) / 10;  // pulse 12 ns -> 2 (setup 9 -> 1, grade-1 -> 1)
  localparam int F_TA = (9 + 9) / 10;   // release 9 ns -> 1
  localparam int H_RD = (12 + 9) / 10;  // grade 12: 2
  localparam int H_WR = (8 + 9) / 10;   // pulse 8 -> 1, setup 6 -> 1, grade-1 -> 1
  localparam int H_TA = (6 + 9) / 10;   // release 6 ns -> 1

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // full-width instance
  logic        f_valid = 0, f_write = 0;
  logic [18:0] f_addr = '0;
  logic [31:0] f_wdata = '0;
  logic [3:0]  f_be = '0;
  logic        f_ready, f_rsp_v, f_we_n, f_oe_n;
  logic [31:0] f_rsp_d;
  logic [18:0] f_maddr;
  logic [3:0]  f_ce_n;
  wire  [31:0] f_dq;

  sram_lane_ctrl #(.CLK_PERIOD_NS(10), .GRADE_NS(20), .HALF_MODE(0)) u_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(f_valid), .req_ready(f_ready), .req_write(f_write),
    .req_addr(f_addr), .req_wdata(f_wdata), .req_be(f_be), .rsp_valid(f_rsp_v),
    .rsp_rdata(f_rsp_d), .mem_addr(f_maddr), .mem_ce_n(f_ce_n), .mem_we_n(f_we_n),
    .mem_oe_n(f_oe_n), .mem_dq(f_dq));

  // half-width instance
  logic        h_valid = 0, h_write = 0;
  logic [19:0] h_addr = '0;
  logic [31:0] h_wdata = '0;
  logic [3:0]  h_be = '0;
  logic        h_ready, h_rsp_v, h_we_n, h_oe_n;
  logic [31:0] h_rsp_d;
  logic [18:0] h_maddr;
  logic [3:0]  h_ce_n;
  wire  [31:0] h_dq;

  sram_lane_ctrl #(.CLK_PERIOD_NS(10), .GRADE_NS(12), .HALF_MODE(1)) u_sram_lane_ctrl_half (
    .clk(clk), .rst_n(rst_n), .req_valid(h_valid), .req_ready(h_ready), .req_write(h_write),
    .req_addr(h_addr), .req_wdata(h_wdata), .req_be(h_be), .rsp_valid(h_rsp_v),
    .rsp_rdata(h_rsp_d), .mem_addr(h_maddr), .mem_ce_n(h_ce_n), .mem_we_n(h_we_n),
    .mem_oe_n(h_oe_n), .mem_dq(h_dq));

  // memory models and shadow copies
  logic [31:0] f_mem [256];
  logic [31:0] h_mem [256];
  logic [31:0] f_sh  [256];
  logic [31:0] h_sh  [256];
  initial begin
    for (int i = 0; i < 256; i++) begin
      f_mem[i] = '0; h_mem[i] = '0; f_sh[i] = '0; h_sh[i] = '0;
    end
  end

  assign f_dq = (f_ce_n != 4'hF && !f_oe_n && f_we_n) ? f_mem[f_maddr[7:0]] : 'z;
  assign h_dq = (h_ce_n != 4'hF && !h_oe_n && h_we_n) ? h_mem[h_maddr[7:0]] : 'z;

  always @(negedge clk) begin
    if (!f_we_n)
      for (int i = 0; i < 4; i++)
        if (!f_ce_n[i]) f_mem[f_maddr[7:0]][i*8 +: 8] <= f_dq[i*8 +: 8];
    if (!h_we_n)
      for (int i = 0; i < 4; i++)
        if (!h_ce_n[i]) h_mem[h_maddr[7:0]][i*8 +: 8] <= h_dq[i*8 +: 8];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  bit f_last_rd = 0;
  bit h_last_rd = 0;

  task automatic f_issue(input bit w, input logic [18:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    while (!f_ready) @(negedge clk);
    f_valid = 1; f_write = w; f_addr = a; f_wdata = d; f_be = be;
    @(posedge clk); #1 f_valid = 0;
  endtask

  task automatic f_write_op(input logic [18:0] a, input logic [31:0] d, input logic [3:0] be);
    int gap = 0;
    int w = 0;
    int exp_gap = f_last_rd ? F_TA : 0;
    f_issue(1, a, d, be);
    @(negedge clk);
    while (f_we_n) begin gap++; @(negedge clk); end
    chk(gap == exp_gap, "R7", "cycles before write strobe", 32'(gap), 32'(exp_gap));
    chk(f_ce_n == ~be, "R5", "write lane enables", {28'h0, f_ce_n}, {28'h0, ~be});
    chk(f_oe_n == 1'b1, "R2", "oe during write", {31'h0, f_oe_n}, 32'h1);
    chk(f_dq == d, "R4", "bus write data", f_dq, d);
    chk(f_maddr == a, "R4", "write address", {13'h0, f_maddr}, {13'h0, a});
    while (!f_we_n) begin w++; @(negedge clk); end
    chk(w == F_WR, "R8", "write pulse cycles", 32'(w), 32'(F_WR));
    for (int i = 0; i < 4; i++) if (be[i]) f_sh[a[7:0]][i*8 +: 8] = d[i*8 +: 8];
    f_last_rd = 0;
  endtask

  task automatic f_read_op(input logic [18:0] a);
    int o = 0;
    logic [31:0] exp = f_sh[a[7:0]];
    f_issue(0, a, '0, '0);
    @(negedge clk);
    while (!f_oe_n) begin
      o++;
      if (o == 1) begin
        chk(f_ce_n == 4'h0, "R5", "read lane enables", {28'h0, f_ce_n}, 32'h0);
        chk(f_maddr == a, "R3", "read address", {13'h0, f_maddr}, {13'h0, a});
      end
      @(negedge clk);
    end
    chk(o == F_RD, "R8", "read window cycles", 32'(o), 32'(F_RD));
    chk(f_rsp_v == 1'b1, "R3", "response valid", {31'h0, f_rsp_v}, 32'h1);
    chk(f_rsp_d == exp, "R9", "read data", f_rsp_d, exp);
    @(negedge clk);
    chk(f_rsp_v == 1'b0, "R3", "response one cycle", {31'h0, f_rsp_v}, 32'h0);
    f_last_rd = 1;
  endtask

  task automatic h_issue(input bit w, input logic [19:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    while (!h_ready) @(negedge clk);
    h_valid = 1; h_write = w; h_addr = a; h_wdata = d; h_be = be;
    @(posedge clk); #1 h_valid = 0;
  endtask

  task automatic h_write_op(input logic [19:0] a, input logic [15:0] d, input logic [3:0] be);
    int gap = 0;
    int w = 0;
    int exp_gap = h_last_rd ? H_TA : 0;
    logic [3:0] lanes = a[0] ? {be[1:0], 2'b00} : {2'b00, be[1:0]};
    logic [15:0] bus_half;
    h_issue(1, a, {16'hFFFF, d}, be);
    @(negedge clk);
    while (h_we_n) begin gap++; @(negedge clk); end
    chk(gap == exp_gap, "R7", "half cycles before write strobe", 32'(gap), 32'(exp_gap));
    chk(h_ce_n == ~lanes, "R6", "half lane enables", {28'h0, h_ce_n}, {28'h0, ~lanes});
    chk(h_maddr == a[19:1], "R6", "half word address", {13'h0, h_maddr}, {13'h0, a[19:1]});
    bus_half = a[0] ? h_dq[31:16] : h_dq[15:0];
    chk(bus_half == d, "R6", "half bus data", {16'h0, bus_half}, {16'h0, d});
    while (!h_we_n) begin w++; @(negedge clk); end
    chk(w == H_WR, "R8", "half write pulse cycles", 32'(w), 32'(H_WR));
    for (int i = 0; i < 2; i++)
      if (be[i]) h_sh[a[8:1]][(a[0] ? 16 : 0) + i*8 +: 8] = d[i*8 +: 8];
    h_last_rd = 0;
  endtask

  task automatic h_read_op(input logic [19:0] a);
    int o = 0;
    logic [31:0] word = h_sh[a[8:1]];
    logic [31:0] exp = a[0] ? {16'h0, word[31:16]} : {16'h0, word[15:0]};
    logic [3:0] lanes = a[0] ? 4'b1100 : 4'b0011;
    h_issue(0, a, '0, '0);
    @(negedge clk);
    while (!h_oe_n) begin
      o++;
      if (o == 1) chk(h_ce_n == ~lanes, "R6", "half read enables", {28'h0, h_ce_n}, {28'h0, ~lanes});
      @(negedge clk);
    end
    chk(o == H_RD, "R8", "half read window", 32'(o), 32'(H_RD));
    chk(h_rsp_v == 1'b1, "R3", "half response valid", {31'h0, h_rsp_v}, 32'h1);
    chk(h_rsp_d == exp, "R6", "half read data", h_rsp_d, exp);
    h_last_rd = 1;
  endtask

  // R1: reset and idle state
  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(f_ce_n == 4'hF, "R1", "enables in reset", {28'h0, f_ce_n}, 32'hF);
    chk(f_we_n && f_oe_n, "R1", "strobes in reset", {30'h0, f_we_n, f_oe_n}, 32'h3);
    chk(f_rsp_v == 1'b0, "R1", "response in reset", {31'h0, f_rsp_v}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(f_ready == 1'b1, "R1", "ready after reset", {31'h0, f_ready}, 32'h1);
    chk(h_ce_n == 4'hF && h_ready, "R1", "half idle", {27'h0, h_ready, h_ce_n}, 32'h1F);
  endtask

  // R10: a request held during a busy read is not taken
  task automatic t_busy_ignored;
    bit bad_ready = 0;
    bit bad_we = 0;
    f_issue(0, 19'd7, '0, '0);
    @(negedge clk);
    f_valid = 1; f_write = 1; f_addr = 19'd8; f_wdata = 32'hFFFFFFFF; f_be = 4'hF;
    while (!f_oe_n) begin
      if (f_ready) bad_ready = 1;
      if (!f_we_n) bad_we = 1;
      @(negedge clk);
    end
    f_valid = 0;
    chk(!bad_ready, "R10", "ready low while busy", {31'h0, bad_ready}, 32'h0);
    chk(!bad_we, "R10", "no write strobe while busy", {31'h0, bad_we}, 32'h0);
    f_last_rd = 1;
    f_read_op(19'd8);  // R10: word 8 still holds its old value
  endtask

  initial begin
    t_reset();
    f_write_op(19'd5, 32'hA5A51234, 4'hF);
    f_read_op(19'd5);
    f_write_op(19'd6, 32'h11223344, 4'b0101);   // R7 after read, R5 partial lanes
    f_write_op(19'd7, 32'hCAFEF00D, 4'hF);      // R7 after write
    f_read_op(19'd6);
    f_write_op(19'd5, 32'hDEADBEEF, 4'h0);      // R5 no strobes
    f_read_op(19'd5);
    t_busy_ignored();
    h_write_op(20'h10, 16'hBEEF, 4'hF);         // R6 upper strobes ignored
    h_write_op(20'h11, 16'h1234, 4'b1101);      // R6 only strobe bit 0 on upper half
    h_read_op(20'h10);
    h_read_op(20'h11);
    h_write_op(20'h11, 16'h5678, 4'b0011);      // R7 half after read
    h_read_op(20'h11);
    h_read_op(20'h10);
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule